// File: doc/BRIEF.md
# Program Interrupt State-Save Unit

This block records the processor state when a Program-class interrupt is taken. Alongside the take strobe it receives the pending causes: illegal instruction, privileged instruction, trap, unimplemented operation and floating-point enabled. It also receives the attributes of the faulting instruction, the current machine state word and the candidate return addresses. On the take edge it loads four registers: the saved address, the saved machine state, the rewritten machine state and a syndrome word that tells the handler why it was entered.

It also watches writes to the machine state word. A write can move the floating-point exception mode field from zero to non-zero while a floating-point exception summary is already pending. In that case the unit latches an imprecise request and records the address of the instruction after the mode-changing write. If that write was done by a return-from-interrupt instruction, it records the return target instead. It then raises a request output. The surrounding pipeline answers that request with a take strobe. The resulting interrupt carries the imprecise flag in its syndrome.

Top module: `prog_irq_save`

## Requirements
- R1: After reset, saveAddr, saveMsw, mswNew and syndrome are all zero and impReq is low.
- R2: The four result registers change only on a rising edge where takeIrq is high and at least one cause is active. A cause is any cause input or a pending imprecise request. Otherwise they hold their values.
- R3: On a take, saveMsw receives mswCur exactly as presented on that edge.
- R4: On a take, mswNew equals mswCur with only bits 17 (critical enable), 12 (machine-check enable) and 9 (debug enable) kept. Every other bit is zero.
- R5: The syndrome cause bits are illegal = bit 0, privileged = bit 1, trap = bit 2 and unimplemented = bit 3. At most one is set. When several causes are active, the order is illegal, then privileged, then trap, then unimplemented, then precise floating-point enabled, then a pending imprecise request.
- R6: For a precise cause, syndrome bit 4 copies instIsFp and bit 5 copies instIsAux. For an imprecise take, both bits are zero.
- R7: For a precise floating-point enabled take, bit 7 copies instCrUpd, bit 8 copies instIsCmp and bits 11:9 copy instCrField. For any other cause these bits are zero.
- R8: A write is detected when mswWrEn and fpSummary are high, mswCur bits 11 and 8 (the floating-point exception mode field) are both zero, and mswWrData has either bit set. After a detected write, impReq is high from the next cycle. No other condition raises impReq.
- R9: An imprecise take sets syndrome bit 6 and forces bits 11:7 to zero. It loads saveAddr with the address recorded at detection and drops impReq on the same edge. For a detected write with mswWrIsRfi low, that address is nextAddr.
- R10: If mswWrIsRfi is high on the detected write, the recorded address is rfiTarget instead of nextAddr.
- R11: On a precise take, saveAddr receives faultAddr.
- R12: A detection on the same edge as a take of another cause does not change that take. The request is still raised afterwards. A precise floating-point enabled cause wins over a pending request and leaves it pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| takeIrq | input | 1 | Interrupt-take strobe |
| causeIll | input | 1 | Illegal instruction cause |
| causePriv | input | 1 | Privileged instruction cause |
| causeTrap | input | 1 | Trap cause |
| causeUnimpl | input | 1 | Unimplemented operation cause |
| causeFpe | input | 1 | Precise floating-point enabled cause |
| instIsFp | input | 1 | Faulting instruction is floating-point |
| instIsAux | input | 1 | Faulting instruction is auxiliary-processor |
| instCrUpd | input | 1 | Faulting instruction updates a condition field |
| instIsCmp | input | 1 | Faulting instruction is a floating-point compare |
| instCrField | input | 3 | Index of the condition field being updated |
| faultAddr | input | ADDR_W | Address of the faulting instruction |
| mswCur | input | MSW_W | Current machine state word |
| mswWrEn | input | 1 | An instruction writes the machine state word |
| mswWrData | input | MSW_W | Value being written |
| mswWrIsRfi | input | 1 | The writer is a return-from-interrupt form |
| nextAddr | input | ADDR_W | Address after the writing instruction |
| rfiTarget | input | ADDR_W | Return target of the writing instruction |
| fpSummary | input | 1 | Floating-point exception summary pending |
| impReq | output | 1 | Imprecise interrupt request pending |
| saveAddr | output | ADDR_W | Saved address register |
| saveMsw | output | MSW_W | Saved machine state register |
| mswNew | output | MSW_W | Rewritten machine state word |
| syndrome | output | 12 | Exception syndrome word |

## Verification
Two functions can fall in the same cycle: detecting a write that enables the floating-point exception mode, and taking an interrupt for a different cause. The bench provokes this by driving a qualifying write together with a take strobe and an illegal-instruction cause. It expects the illegal take to complete untouched and impReq to rise on that same edge. It then takes a precise floating-point enabled cause while the request is pending, and expects the request to survive. Finally it expects a causeless take to deliver the imprecise syndrome with the address recorded at detection.

// File: rtl/pis_pkg.sv
package pis_pkg;

  // Selected interrupt source, in descending priority after SEL_NONE
  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_ILL    = 3'd1,
    SEL_PRIV   = 3'd2,
    SEL_TRAP   = 3'd3,
    SEL_UNIMPL = 3'd4,
    SEL_FPE    = 3'd5,
    SEL_IMP    = 3'd6
  } sel_e;

  // Syndrome word, bit 11 down to bit 0
  typedef struct packed {
    logic [2:0] crField;   // 11:9
    logic       cmpHit;    // 8
    logic       crUpd;     // 7
    logic       imprecise; // 6
    logic       auxInst;   // 5
    logic       fpInst;    // 4
    logic       unimpl;    // 3
    logic       trap;      // 2
    logic       priv;      // 1
    logic       illegal;   // 0
  } syndrome_t;

  localparam int SYN_W = $bits(syndrome_t);

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    sel_e sel;
    logic capPend;
    logic capUseRfi;
  } strobes_t;

endpackage

// File: rtl/pis_ctrl.sv
module pis_ctrl
  import pis_pkg::*;
#(
  parameter int MSW_W     = 32,
  parameter int FE_HI_BIT = 11,
  parameter int FE_LO_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             takeIrq,
  input  logic             causeIll,
  input  logic             causePriv,
  input  logic             causeTrap,
  input  logic             causeUnimpl,
  input  logic             causeFpe,
  input  logic [MSW_W-1:0] mswCur,
  input  logic             mswWrEn,
  input  logic [MSW_W-1:0] mswWrData,
  input  logic             mswWrIsRfi,
  input  logic             fpSummary,
  output strobes_t         strobes,
  output logic             impReq
);

  logic [1:0] feOld;
  logic [1:0] feNew;
  logic       detect;
  sel_e       selNow;
  logic       loadNow;

  assign feOld  = {mswCur[FE_HI_BIT], mswCur[FE_LO_BIT]};
  assign feNew  = {mswWrData[FE_HI_BIT], mswWrData[FE_LO_BIT]};
  assign detect = mswWrEn && fpSummary && (feOld == 2'b00) && (feNew != 2'b00);

  // Fixed-priority cause selection
  always_comb begin
    if (causeIll)         selNow = SEL_ILL;
    else if (causePriv)   selNow = SEL_PRIV;
    else if (causeTrap)   selNow = SEL_TRAP;
    else if (causeUnimpl) selNow = SEL_UNIMPL;
    else if (causeFpe)    selNow = SEL_FPE;
    else if (impReq)      selNow = SEL_IMP;
    else                  selNow = SEL_NONE;
  end

  assign loadNow = takeIrq && (selNow != SEL_NONE);

  always_comb begin
    strobes.load      = loadNow;
    strobes.sel       = selNow;
    strobes.capPend   = detect;
    strobes.capUseRfi = mswWrIsRfi;
  end

  // Pending imprecise request; a fresh detection wins over a clear
  always_ff @(posedge clk) begin
    if (!rst_n)                            impReq <= 1'b0;
    else if (detect)                       impReq <= 1'b1;
    else if (loadNow && selNow == SEL_IMP) impReq <= 1'b0;
  end

endmodule

// File: rtl/pis_dpath.sv
module pis_dpath
  import pis_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MSW_W  = 32,
  parameter int CE_BIT = 17,
  parameter int ME_BIT = 12,
  parameter int DE_BIT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          strobes,
  input  logic              instIsFp,
  input  logic              instIsAux,
  input  logic              instCrUpd,
  input  logic              instIsCmp,
  input  logic [2:0]        instCrField,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [MSW_W-1:0]  mswCur,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [ADDR_W-1:0] rfiTarget,
  output logic [ADDR_W-1:0] saveAddr,
  output logic [MSW_W-1:0]  saveMsw,
  output logic [MSW_W-1:0]  mswNew,
  output logic [SYN_W-1:0]  syndrome
);

  localparam logic [MSW_W-1:0] KEEP_MASK =
    (MSW_W'(1) << CE_BIT) | (MSW_W'(1) << ME_BIT) | (MSW_W'(1) << DE_BIT);

  logic [ADDR_W-1:0] pendAddr;
  syndrome_t         synNext;
  logic [ADDR_W-1:0] addrNext;
  logic              precise;

  assign precise = (strobes.sel != SEL_IMP) && (strobes.sel != SEL_NONE);

  always_comb begin
    synNext           = '0;
    synNext.illegal   = (strobes.sel == SEL_ILL);
    synNext.priv      = (strobes.sel == SEL_PRIV);
    synNext.trap      = (strobes.sel == SEL_TRAP);
    synNext.unimpl    = (strobes.sel == SEL_UNIMPL);
    synNext.fpInst    = precise && instIsFp;
    synNext.auxInst   = precise && instIsAux;
    synNext.imprecise = (strobes.sel == SEL_IMP);
    if (strobes.sel == SEL_FPE) begin
      synNext.crUpd   = instCrUpd;
      synNext.cmpHit  = instIsCmp;
      synNext.crField = instCrField;
    end
  end

  assign addrNext = (strobes.sel == SEL_IMP) ? pendAddr : faultAddr;

  always_ff @(posedge clk) begin
    if (!rst_n) pendAddr <= '0;
    else if (strobes.capPend) pendAddr <= strobes.capUseRfi ? rfiTarget : nextAddr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      saveAddr <= '0;
      saveMsw  <= '0;
      mswNew   <= '0;
      syndrome <= '0;
    end else if (strobes.load) begin
      saveAddr <= addrNext;
      saveMsw  <= mswCur;
      mswNew   <= mswCur & KEEP_MASK;
      syndrome <= synNext;
    end
  end

endmodule

// File: rtl/prog_irq_save.sv
module prog_irq_save
  import pis_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int MSW_W     = 32,
  parameter int CE_BIT    = 17,
  parameter int ME_BIT    = 12,
  parameter int DE_BIT    = 9,
  parameter int FE_HI_BIT = 11,
  parameter int FE_LO_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              takeIrq,
  input  logic              causeIll,
  input  logic              causePriv,
  input  logic              causeTrap,
  input  logic              causeUnimpl,
  input  logic              causeFpe,
  input  logic              instIsFp,
  input  logic              instIsAux,
  input  logic              instCrUpd,
  input  logic              instIsCmp,
  input  logic [2:0]        instCrField,
  input  logic [ADDR_W-1:0] faultAddr,
  input  logic [MSW_W-1:0]  mswCur,
  input  logic              mswWrEn,
  input  logic [MSW_W-1:0]  mswWrData,
  input  logic              mswWrIsRfi,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [ADDR_W-1:0] rfiTarget,
  input  logic              fpSummary,
  output logic              impReq,
  output logic [ADDR_W-1:0] saveAddr,
  output logic [MSW_W-1:0]  saveMsw,
  output logic [MSW_W-1:0]  mswNew,
  output logic [11:0]       syndrome
);

  strobes_t strobes;

  pis_ctrl #(
    .MSW_W(MSW_W), .FE_HI_BIT(FE_HI_BIT), .FE_LO_BIT(FE_LO_BIT)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .takeIrq(takeIrq),
    .causeIll(causeIll), .causePriv(causePriv), .causeTrap(causeTrap),
    .causeUnimpl(causeUnimpl), .causeFpe(causeFpe),
    .mswCur(mswCur), .mswWrEn(mswWrEn), .mswWrData(mswWrData),
    .mswWrIsRfi(mswWrIsRfi), .fpSummary(fpSummary),
    .strobes(strobes), .impReq(impReq)
  );

  pis_dpath #(
    .ADDR_W(ADDR_W), .MSW_W(MSW_W),
    .CE_BIT(CE_BIT), .ME_BIT(ME_BIT), .DE_BIT(DE_BIT)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .instIsFp(instIsFp), .instIsAux(instIsAux), .instCrUpd(instCrUpd),
    .instIsCmp(instIsCmp), .instCrField(instCrField),
    .faultAddr(faultAddr), .mswCur(mswCur),
    .nextAddr(nextAddr), .rfiTarget(rfiTarget),
    .saveAddr(saveAddr), .saveMsw(saveMsw), .mswNew(mswNew),
    .syndrome(syndrome)
  );

endmodule

// File: rtl/pis_chk.sv
module pis_chk #(
  parameter int ADDR_W    = 32,
  parameter int MSW_W     = 32,
  parameter int CE_BIT    = 17,
  parameter int ME_BIT    = 12,
  parameter int DE_BIT    = 9,
  parameter int FE_HI_BIT = 11,
  parameter int FE_LO_BIT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              takeIrq,
  input logic              causeIll,
  input logic              causePriv,
  input logic              causeTrap,
  input logic              causeUnimpl,
  input logic              causeFpe,
  input logic [MSW_W-1:0]  mswCur,
  input logic              mswWrEn,
  input logic [MSW_W-1:0]  mswWrData,
  input logic              fpSummary,
  input logic              impReq,
  input logic [ADDR_W-1:0] saveAddr,
  input logic [MSW_W-1:0]  saveMsw,
  input logic [MSW_W-1:0]  mswNew,
  input logic [11:0]       syndrome
);

  localparam logic [MSW_W-1:0] KEEP_MASK =
    (MSW_W'(1) << CE_BIT) | (MSW_W'(1) << ME_BIT) | (MSW_W'(1) << DE_BIT);

  logic anyCause;
  logic feUp;
  assign anyCause = causeIll | causePriv | causeTrap | causeUnimpl | causeFpe | impReq;
  assign feUp = mswWrEn && fpSummary &&
                !mswCur[FE_HI_BIT] && !mswCur[FE_LO_BIT] &&
                (mswWrData[FE_HI_BIT] || mswWrData[FE_LO_BIT]);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !takeIrq |=> $stable(saveAddr) && $stable(saveMsw) && $stable(mswNew) && $stable(syndrome));

  // R3
  msw_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (takeIrq && anyCause) |=> saveMsw == $past(mswCur));

  // R4
  keep_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mswNew & ~KEEP_MASK) == '0);

  // R5
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(syndrome[3:0]));

  // R9
  imprecise_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    syndrome[6] |-> (syndrome[11:7] == 5'd0 && syndrome[3:0] == 4'd0));

  // R8
  detect_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feUp |=> impReq);

endmodule

bind prog_irq_save pis_chk #(
  .ADDR_W(ADDR_W), .MSW_W(MSW_W), .CE_BIT(CE_BIT), .ME_BIT(ME_BIT),
  .DE_BIT(DE_BIT), .FE_HI_BIT(FE_HI_BIT), .FE_LO_BIT(FE_LO_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .takeIrq(takeIrq),
  .causeIll(causeIll), .causePriv(causePriv), .causeTrap(causeTrap),
  .causeUnimpl(causeUnimpl), .causeFpe(causeFpe),
  .mswCur(mswCur), .mswWrEn(mswWrEn), .mswWrData(mswWrData),
  .fpSummary(fpSummary), .impReq(impReq), .saveAddr(saveAddr),
  .saveMsw(saveMsw), .mswNew(mswNew), .syndrome(syndrome)
);

// File: tb/tb_prog_irq_save.sv
`timescale 1ns/1ps
module tb_prog_irq_save;

  localparam logic [31:0] KEEP = 32'h0002_1200; // bits 17, 12, 9

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic takeIrq, causeIll, causePriv, causeTrap, causeUnimpl, causeFpe;
  logic instIsFp, instIsAux, instCrUpd, instIsCmp;
  logic [2:0] instCrField;
  logic [31:0] faultAddr, mswCur, mswWrData, nextAddr, rfiTarget;
  logic mswWrEn, mswWrIsRfi, fpSummary;
  logic impReq;
  logic [31:0] saveAddr, saveMsw, mswNew;
  logic [11:0] syndrome;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prog_irq_save dut (.*);

  typedef struct {
    string req;
    logic [31:0] addr, msw, newMsw;
    logic [11:0] syn;
    logic imp;
  } exp_t;

  exp_t q[$];

  // Bench reference state
  logic [31:0] mAddr = '0, mMsw = '0, mNew = '0, mPendAddr = '0;
  logic [11:0] mSyn = '0;
  logic mPend = 1'b0;

  task automatic clr();
    takeIrq = 0; causeIll = 0; causePriv = 0; causeTrap = 0; causeUnimpl = 0;
    causeFpe = 0; instIsFp = 0; instIsAux = 0; instCrUpd = 0; instIsCmp = 0;
    instCrField = 0; faultAddr = 0; mswCur = 0; mswWrData = 0; nextAddr = 0;
    rfiTarget = 0; mswWrEn = 0; mswWrIsRfi = 0; fpSummary = 0;
  endtask

  // Compute expected result of the current inputs, clock once, enqueue
  task automatic step(input string req);
    int sel;
    bit det;
    exp_t e;
    if (causeIll) sel = 1; else if (causePriv) sel = 2; else if (causeTrap) sel = 3;
    else if (causeUnimpl) sel = 4; else if (causeFpe) sel = 5; else if (mPend) sel = 6;
    else sel = 0;
    det = mswWrEn && fpSummary && !mswCur[11] && !mswCur[8] && (mswWrData[11] || mswWrData[8]);
    if (takeIrq && sel != 0) begin
      mMsw = mswCur;
      mNew = mswCur & KEEP;
      mSyn = '0;
      if (sel >= 1 && sel <= 4) mSyn[sel-1] = 1'b1;
      if (sel != 6) begin
        mSyn[4] = instIsFp; mSyn[5] = instIsAux; mAddr = faultAddr;
      end else begin
        mSyn[6] = 1'b1; mAddr = mPendAddr;
      end
      if (sel == 5) begin
        mSyn[7] = instCrUpd; mSyn[8] = instIsCmp; mSyn[11:9] = instCrField;
      end
    end
    if (det) begin
      mPend = 1'b1;
      mPendAddr = mswWrIsRfi ? rfiTarget : nextAddr;
    end else if (takeIrq && sel == 6) begin
      mPend = 1'b0;
    end
    e.req = req; e.addr = mAddr; e.msw = mMsw; e.newMsw = mNew; e.syn = mSyn; e.imp = mPend;
    @(posedge clk);
    q.push_back(e);
    @(negedge clk);
  endtask

  // Monitor: compare one expected item per cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (saveAddr !== e.addr || saveMsw !== e.msw || mswNew !== e.newMsw ||
          syndrome !== e.syn || impReq !== e.imp) begin
        failures++;
        $display("FAIL %s: addr=%h/%h msw=%h/%h new=%h/%h syn=%h/%h imp=%b/%b (actual/expected)",
                 e.req, saveAddr, e.addr, saveMsw, e.msw, mswNew, e.newMsw,
                 syndrome, e.syn, impReq, e.imp);
      end
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (saveAddr !== 0 || saveMsw !== 0 || mswNew !== 0 || syndrome !== 0 || impReq !== 0) begin
      failures++;
      $display("FAIL R1: addr=%h msw=%h new=%h syn=%h imp=%b expected all zero",
               saveAddr, saveMsw, mswNew, syndrome, impReq);
    end

    // R2 take with no cause, and a cause without take: hold
    clr(); takeIrq = 1; mswCur = 32'hFFFF_FFFF; faultAddr = 32'h1234; step("R2 take_no_cause");
    clr(); causeIll = 1; mswCur = 32'hFFFF_FFFF; step("R2 cause_no_take");

    // R3 R4 R5 R11 R6 illegal with fp attribute
    clr(); takeIrq = 1; causeIll = 1; instIsFp = 1; mswCur = 32'hA5A5_F3F3;
    faultAddr = 32'h0000_1000; step("R3 R4 R5 R11 R6 illegal_fp");
    // R2 hold after
    clr(); mswCur = 32'h1111_1111; faultAddr = 32'h77; step("R2 hold_idle");

    // R5 priority
    clr(); takeIrq = 1; causeIll = 1; causePriv = 1; causeTrap = 1; causeUnimpl = 1; causeFpe = 1;
    instCrUpd = 1; instCrField = 3'd6; mswCur = 32'hFFFF_FFFF; faultAddr = 32'h2000;
    step("R5 R7 all_causes_illegal");
    clr(); takeIrq = 1; causePriv = 1; causeTrap = 1; instIsAux = 1; mswCur = 32'h0002_0000;
    faultAddr = 32'h2004; step("R5 R6 priv_over_trap");
    clr(); takeIrq = 1; causeTrap = 1; causeUnimpl = 1; causeFpe = 1; mswCur = 32'h0000_1200;
    faultAddr = 32'h2008; step("R5 trap_over_unimpl");
    clr(); takeIrq = 1; causeUnimpl = 1; causeFpe = 1; mswCur = 32'h5555_5555;
    faultAddr = 32'h200C; step("R5 unimpl_over_fpe");

    // R7 precise floating-point enabled
    clr(); takeIrq = 1; causeFpe = 1; instIsFp = 1; instCrUpd = 1; instIsCmp = 1;
    instCrField = 3'd5; mswCur = 32'h0000_0900; faultAddr = 32'h3000;
    step("R7 R6 fpe_cr_cmp_field5");
    clr(); takeIrq = 1; causeFpe = 1; instCrField = 3'd7; instIsAux = 1; mswCur = 32'hCAFE_BABE;
    faultAddr = 32'h3004; step("R7 fpe_field7_aux");

    // R8 negative: no summary, or field already non-zero
    clr(); mswWrEn = 1; mswWrData = 32'h0000_0800; step("R8 no_summary");
    clr(); mswWrEn = 1; fpSummary = 1; mswCur = 32'h0000_0100; mswWrData = 32'h0000_0900;
    step("R8 field_already_on");
    clr(); takeIrq = 1; mswCur = 32'h1; step("R2 take_nothing_pending");

    // R8 R9 detection then imprecise take
    clr(); mswWrEn = 1; fpSummary = 1; mswWrData = 32'h0000_0800; nextAddr = 32'h4004;
    rfiTarget = 32'h9990; step("R8 detect");
    clr(); step("R8 R2 pending_hold");
    clr(); takeIrq = 1; instIsFp = 1; instIsAux = 1; instCrUpd = 1; instIsCmp = 1; instCrField = 3'd3;
    mswCur = 32'h0000_0800; faultAddr = 32'hDEAD; step("R9 imprecise_take");

    // R10 rfi writer
    clr(); mswWrEn = 1; mswWrIsRfi = 1; fpSummary = 1; mswWrData = 32'h0000_0100;
    nextAddr = 32'h5004; rfiTarget = 32'h6000; step("R10 detect_rfi");
    clr(); takeIrq = 1; mswCur = 32'h0003_F100; step("R10 R9 imprecise_rfi_take");

    // R12 detection coincident with illegal take
    clr(); takeIrq = 1; causeIll = 1; mswCur = 32'h0000_0000; faultAddr = 32'h7000;
    mswWrEn = 1; fpSummary = 1; mswWrData = 32'h0000_0900; nextAddr = 32'h7004;
    rfiTarget = 32'h8000; step("R12 detect_with_illegal");
    clr(); takeIrq = 1; causeFpe = 1; instCrUpd = 1; instCrField = 3'd2; mswCur = 32'h0000_0900;
    faultAddr = 32'h7100; step("R12 precise_fpe_beats_pending");
    clr(); takeIrq = 1; mswCur = 32'h0000_0900; faultAddr = 32'h7200; step("R12 R9 pending_taken");
    clr(); step("R2 final_hold");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule